// File: doc/BRIEF.md
# Per-Halfword Odd Parity Checker

This block sits on the receive side of a cell-based switch fabric link, after the double-data-rate pins have been split into two 16-bit slices per clock cycle. Slice 0 holds the bits taken on the rising edge and slice 1 the bits taken on the falling edge. Each slice carries its own parity bit. When a word is marked valid, the block checks every slice for odd parity on its own. A single mismatch in any slice sets a per-frame error flag. That flag stays set until the frame ends.

The frame boundary is given by an end-of-frame strobe that comes in the same cycle as the final word. On that strobe the block presents the frame's parity verdict with a one-cycle valid pulse and then clears the flag for the next frame. A mismatch also has two side effects. It withdraws both ready indications toward the fabric. It also sets a sticky interrupt status bit, which drives the interrupt line only while the interrupt is enabled. Software re-arms the ready indications with an explicit set input and clears the interrupt bit with a write-one-to-clear input.

Top module: `slice_parity_checker`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `frm_stat_vld`, `frm_stat_err`, `irq_sticky` and `irq_out` are 0, and `ctl_rdy` and `dat_rdy` are 1.
- R2: A slice passes when its 16 data bits plus its parity bit contain an odd number of ones, and fails otherwise. The data value does not affect this rule, so all-zero data with parity 1 passes and all-zero data with parity 0 fails.
- R3: Slice 0 (bits `[15:0]`, parity bit 0) and slice 1 (bits `[31:16]`, parity bit 1) are checked independently. A failure in either slice alone marks the frame as errored.
- R4: A mismatch on any valid word of a frame sets the frame flag. The flag stays set through later clean words, so the frame's status reports an error.
- R5: After each end-of-frame strobe the flag is cleared, so a later frame with only clean words reports no error.
- R6: A mismatch on the word that arrives in the same cycle as the end-of-frame strobe is included in that frame's status.
- R7: `frm_stat_vld` is 1 for exactly the one cycle after each end-of-frame strobe and 0 otherwise. `frm_stat_err` is meaningful in that cycle.
- R8: Slices presented while `word_vld` is 0 are not checked. They change neither the frame status, nor the ready outputs, nor the interrupt bit.
- R9: One cycle after a valid word with a mismatch, `ctl_rdy` and `dat_rdy` are both 0. They stay 0 until a cycle with `rdy_set` high and return to 1 the cycle after it. A mismatch in the same cycle as `rdy_set` wins.
- R10: One cycle after a valid word with a mismatch, `irq_sticky` is 1. It stays 1 until a cycle with `irq_clr` high and is 0 the cycle after it. A mismatch in the same cycle as `irq_clr` wins.
- R11: `irq_out` equals `irq_sticky` AND `irq_en`. It follows `irq_en` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_vld | input | 1 | Slices and parity bits hold a received word |
| slice_data | input | 32 | Slice 0 (rising edge) in [15:0], slice 1 (falling edge) in [31:16] |
| slice_par | input | 2 | Received parity bit for each slice |
| frame_end | input | 1 | The current cycle closes the frame |
| rdy_set | input | 1 | Software request to re-assert both ready indications |
| irq_clr | input | 1 | Write-one-to-clear for the sticky interrupt bit |
| irq_en | input | 1 | Interrupt enable |
| frm_stat_vld | output | 1 | One-cycle pulse: frame status available |
| frm_stat_err | output | 1 | Parity error seen in the frame just closed |
| ctl_rdy | output | 1 | Control-traffic ready indication toward the fabric |
| dat_rdy | output | 1 | Data-traffic ready indication toward the fabric |
| irq_sticky | output | 1 | Sticky parity-error interrupt status |
| irq_out | output | 1 | Interrupt request |

## Verification
The frame status, the ready outputs and the sticky interrupt bit are each one register stage behind their cause. They are due in the cycle right after the edge that samples the end-of-frame strobe or the failing word. `irq_out` is combinational on top of the sticky bit. The bench drives every stimulus on the falling clock edge, lets one rising edge pass, and samples shortly after that edge, so each check looks at exactly the cycle where its result is due. For the enable gating, the bench changes `irq_en` between edges and reads `irq_out` before the next rising edge.

// File: rtl/sp_pkg.sv
// Package: shared sizing and types for the slice parity checker.
// Assumes a link that delivers a fixed number of equal-width slices per cycle.
package sp_pkg;
    localparam int unsigned SP_SLICE_W    = 16;  // bits per slice
    localparam int unsigned SP_NUM_SLICES = 2;   // slices per cycle (one per edge)
    localparam int unsigned SP_NUM_RDY    = 2;   // ready lines toward the fabric

    // Registered per-frame verdict.
    typedef struct packed {
        logic vld;
        logic err;
    } sp_frame_stat_t;
endpackage

// File: rtl/sp_slice_check.sv
// Module: sp_slice_check
// Compares one slice with its received parity bit under the odd-parity rule.
// Assumes: the slice and parity arrive in the same cycle; purely combinational.
module sp_slice_check #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] data,
    input  logic         par,
    input  logic         vld,
    output logic         mismatch
);
    logic total_odd;

    // Purpose: reduce data and parity to a single ones-count parity.
    always_comb begin
        total_odd = ^{data, par};
    end

    // Purpose: flag a slice whose ones count is even, but only when valid.
    always_comb begin
        mismatch = vld & ~total_odd;
    end
endmodule

// File: rtl/sp_frame_flag.sv
// Module: sp_frame_flag
// Holds the per-frame sticky error flag and emits the frame verdict.
// Assumes: frame_end comes in the same cycle as the final word. That word's
// result is folded into the verdict before the flag restarts.
module sp_frame_flag
    import sp_pkg::*;
#(
    parameter int unsigned NUM_SLICES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SLICES-1:0] slice_miss,
    input  logic                  frame_end,
    output sp_frame_stat_t        stat,
    output logic                  err_evt
);
    logic           flag_q;
    logic           flag_nxt;
    sp_frame_stat_t stat_q;

    // Purpose: any slice failing this cycle is an error event.
    always_comb begin
        err_evt = |slice_miss;
    end

    // Purpose: accumulate the current word into the running flag.
    always_comb begin
        flag_nxt = flag_q | err_evt;
    end

    // Purpose: update the flag and capture the verdict at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q     <= 1'b0;
            stat_q.vld <= 1'b0;
            stat_q.err <= 1'b0;
        end else begin
            stat_q.vld <= frame_end;
            if (frame_end) begin
                stat_q.err <= flag_nxt;
                flag_q     <= 1'b0;
            end else begin
                flag_q     <= flag_nxt;
            end
        end
    end

    assign stat = stat_q;
endmodule

// File: rtl/sp_fabric_ctl.sv
// Module: sp_fabric_ctl
// Withdraws the fabric ready lines and keeps the sticky interrupt bit.
// Assumes: err_evt is a one-cycle event per failing word. An event takes
// priority over a software set or clear in the same cycle.
module sp_fabric_ctl #(
    parameter int unsigned NUM_RDY = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               err_evt,
    input  logic               rdy_set,
    input  logic               irq_clr,
    input  logic               irq_en,
    output logic [NUM_RDY-1:0] rdy,
    output logic               irq_sticky,
    output logic               irq_out
);
    logic irq_q;

    // One identical ready register per fabric ready line.
    for (genvar g = 0; g < NUM_RDY; g++) begin : g_rdy
        logic rdy_q;

        // Purpose: drop on an error event, re-arm on a software set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdy_q <= 1'b1;
            end else if (err_evt) begin
                rdy_q <= 1'b0;
            end else if (rdy_set) begin
                rdy_q <= 1'b1;
            end
        end

        assign rdy[g] = rdy_q;
    end

    // Purpose: set the sticky bit on an event, clear it on write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (err_evt) begin
            irq_q <= 1'b1;
        end else if (irq_clr) begin
            irq_q <= 1'b0;
        end
    end

    // Purpose: gate the interrupt request with its enable.
    always_comb begin
        irq_out = irq_q & irq_en;
    end

    assign irq_sticky = irq_q;
endmodule

// File: rtl/slice_parity_checker.sv
// Module: slice_parity_checker
// Top of the receive parity checker. It checks odd parity on every slice of a
// valid word, keeps a per-frame error flag, and reports the verdict one cycle
// after the end-of-frame strobe. It also withdraws fabric readiness and sets a
// sticky interrupt bit on every mismatch.
// Assumes: slices are already deserialized. Slice 0 is the rising-edge slice.
module slice_parity_checker
    import sp_pkg::*;
#(
    parameter int unsigned SLICE_W    = SP_SLICE_W,
    parameter int unsigned NUM_SLICES = SP_NUM_SLICES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          word_vld,
    input  logic [NUM_SLICES*SLICE_W-1:0] slice_data,
    input  logic [NUM_SLICES-1:0]         slice_par,
    input  logic                          frame_end,
    input  logic                          rdy_set,
    input  logic                          irq_clr,
    input  logic                          irq_en,
    output logic                          frm_stat_vld,
    output logic                          frm_stat_err,
    output logic                          ctl_rdy,
    output logic                          dat_rdy,
    output logic                          irq_sticky,
    output logic                          irq_out
);
    localparam int unsigned RDY_CTL = 0;
    localparam int unsigned RDY_DAT = 1;

    logic [NUM_SLICES-1:0] slice_miss;
    logic [SP_NUM_RDY-1:0] rdy_vec;
    logic                  err_evt;
    sp_frame_stat_t        stat;

    // One comparator per slice of the word.
    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        sp_slice_check #(
            .W (SLICE_W)
        ) u_cmp (
            .data     (slice_data[s*SLICE_W +: SLICE_W]),
            .par      (slice_par[s]),
            .vld      (word_vld),
            .mismatch (slice_miss[s])
        );
    end

    sp_frame_flag #(
        .NUM_SLICES (NUM_SLICES)
    ) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .slice_miss (slice_miss),
        .frame_end  (frame_end),
        .stat       (stat),
        .err_evt    (err_evt)
    );

    sp_fabric_ctl #(
        .NUM_RDY (SP_NUM_RDY)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_evt    (err_evt),
        .rdy_set    (rdy_set),
        .irq_clr    (irq_clr),
        .irq_en     (irq_en),
        .rdy        (rdy_vec),
        .irq_sticky (irq_sticky),
        .irq_out    (irq_out)
    );

    assign frm_stat_vld = stat.vld;
    assign frm_stat_err = stat.err;
    assign ctl_rdy      = rdy_vec[RDY_CTL];
    assign dat_rdy      = rdy_vec[RDY_DAT];
endmodule

// File: rtl/sp_checker.sv
// Module: sp_checker
// Property checker bound to slice_parity_checker. It recomputes the slice
// parity from the ports and relates it to the registered outputs.
module sp_checker #(
    parameter int unsigned SLICE_W    = 16,
    parameter int unsigned NUM_SLICES = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          word_vld,
    input logic [NUM_SLICES*SLICE_W-1:0] slice_data,
    input logic [NUM_SLICES-1:0]         slice_par,
    input logic                          frame_end,
    input logic                          rdy_set,
    input logic                          irq_clr,
    input logic                          irq_en,
    input logic                          frm_stat_vld,
    input logic                          frm_stat_err,
    input logic                          ctl_rdy,
    input logic                          dat_rdy,
    input logic                          irq_sticky,
    input logic                          irq_out
);
    logic any_miss;

    // Purpose: independent view of whether the current word fails parity.
    always_comb begin
        any_miss = 1'b0;
        for (int i = 0; i < NUM_SLICES; i++) begin
            if (word_vld && !(^{slice_data[i*SLICE_W +: SLICE_W], slice_par[i]})) begin
                any_miss = 1'b1;
            end
        end
    end

    AST_STAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> frm_stat_vld);                                   // R7
    AST_STAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> !frm_stat_vld);                                 // R7
    AST_LAST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && any_miss) |=> frm_stat_err);                     // R6
    AST_RDY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        any_miss |=> (!ctl_rdy && !dat_rdy));                          // R9
    AST_RDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_rdy && !rdy_set) |=> !ctl_rdy);                          // R9
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        any_miss |=> irq_sticky);                                      // R10
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sticky && !irq_clr) |=> irq_sticky);                      // R10
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_out);                                         // R11
endmodule

bind slice_parity_checker sp_checker #(
    .SLICE_W    (SLICE_W),
    .NUM_SLICES (NUM_SLICES)
) u_sp_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_vld     (word_vld),
    .slice_data   (slice_data),
    .slice_par    (slice_par),
    .frame_end    (frame_end),
    .rdy_set      (rdy_set),
    .irq_clr      (irq_clr),
    .irq_en       (irq_en),
    .frm_stat_vld (frm_stat_vld),
    .frm_stat_err (frm_stat_err),
    .ctl_rdy      (ctl_rdy),
    .dat_rdy      (dat_rdy),
    .irq_sticky   (irq_sticky),
    .irq_out      (irq_out)
);

// File: tb/slice_parity_checker_tb.sv
`timescale 1ns/1ps
// Bench: a table of frame vectors walked by one loop, then directed tests.
module slice_parity_checker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_vld = 1'b0;
    logic [31:0] slice_data = '0;
    logic [1:0]  slice_par = '0;
    logic        frame_end = 1'b0;
    logic        rdy_set = 1'b0;
    logic        irq_clr = 1'b0;
    logic        irq_en = 1'b0;
    logic        frm_stat_vld, frm_stat_err, ctl_rdy, dat_rdy, irq_sticky, irq_out;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;  // 125 MHz

    slice_parity_checker u_dut (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .slice_data(slice_data),
        .slice_par(slice_par), .frame_end(frame_end), .rdy_set(rdy_set),
        .irq_clr(irq_clr), .irq_en(irq_en), .frm_stat_vld(frm_stat_vld),
        .frm_stat_err(frm_stat_err), .ctl_rdy(ctl_rdy), .dat_rdy(dat_rdy),
        .irq_sticky(irq_sticky), .irq_out(irq_out)
    );

    // Vector: {vld, fe, bad0, bad1, d0[15:0], d1[15:0], exp_vld, exp_err}
    localparam int NV = 13;
    localparam logic [37:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,1'b0,16'h0000,16'hFFFF,1'b0,1'b0},
        {1'b1,1'b1,1'b0,1'b0,16'h8001,16'h1234,1'b1,1'b0}, // clean frame, R2
        {1'b1,1'b0,1'b1,1'b0,16'h0000,16'h00FF,1'b0,1'b0}, // slice 0 fails, R3
        {1'b1,1'b0,1'b0,1'b0,16'hA5A5,16'h0F0F,1'b0,1'b0},
        {1'b1,1'b1,1'b0,1'b0,16'h7FFE,16'h0001,1'b1,1'b1}, // flag held, R4
        {1'b1,1'b1,1'b0,1'b0,16'h1111,16'h2222,1'b1,1'b0}, // flag cleared, R5
        {1'b1,1'b0,1'b0,1'b1,16'hC3C3,16'h0000,1'b0,1'b0}, // slice 1 fails, R3
        {1'b1,1'b1,1'b0,1'b0,16'h0101,16'h8000,1'b1,1'b1},
        {1'b0,1'b0,1'b1,1'b1,16'hFFFF,16'hFFFF,1'b0,1'b0}, // invalid word, R8
        {1'b1,1'b1,1'b0,1'b0,16'h4242,16'h2424,1'b1,1'b0}, // R8
        {1'b1,1'b1,1'b1,1'b0,16'h0000,16'h5555,1'b1,1'b1}, // last word fails, R6
        {1'b1,1'b1,1'b0,1'b0,16'h3333,16'hCCCC,1'b1,1'b0},
        {1'b0,1'b1,1'b0,1'b0,16'h0000,16'h0000,1'b1,1'b0}  // empty close, R7
    };

    task automatic check(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
        end
    endtask

    // Drive one word at the falling edge; results are due just after the next rise.
    task automatic drive(input logic v, input logic fe, input logic [15:0] d0, input logic b0,
                         input logic [15:0] d1, input logic b1);
        @(negedge clk);
        word_vld   = v;
        frame_end  = fe;
        slice_data = {d1, d0};
        slice_par  = {~(^d1) ^ b1, ~(^d0) ^ b0};
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: state while reset is held
        repeat (3) @(posedge clk);
        #1;
        check("R1", "stat_vld", frm_stat_vld, 1'b0);
        check("R1", "ctl_rdy", ctl_rdy, 1'b1);
        check("R1", "dat_rdy", dat_rdy, 1'b1);
        check("R1", "irq_sticky", irq_sticky, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "stat_err after reset", frm_stat_err, 1'b0);
        check("R1", "irq_out after reset", irq_out, 1'b0);

        // Table walk: frame verdicts (R2 R3 R4 R5 R6 R7 R8)
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][37], VEC[i][36], VEC[i][33:18], VEC[i][35], VEC[i][17:2], VEC[i][34]);
            check("R7", $sformatf("vec %0d stat_vld", i), frm_stat_vld, VEC[i][1]);
            if (VEC[i][1]) check("R4", $sformatf("vec %0d stat_err", i), frm_stat_err, VEC[i][0]);
        end
        drive(1'b0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0);
        check("R7", "pulse ends", frm_stat_vld, 1'b0);

        // Re-arm: software set and clear
        @(negedge clk);
        rdy_set = 1'b1; irq_clr = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        rdy_set = 1'b0; irq_clr = 1'b0;
        check("R9", "ctl_rdy re-armed", ctl_rdy, 1'b1);
        check("R10", "irq cleared", irq_sticky, 1'b0);

        // R8: bad slices with word_vld low leave ready and interrupt untouched
        drive(1'b0, 1'b0, 16'h00F0, 1'b1, 16'h0000, 1'b1);
        check("R8", "ctl_rdy untouched", ctl_rdy, 1'b1);
        check("R8", "irq untouched", irq_sticky, 1'b0);

        // R9 R10 R11: mismatch with interrupt disabled
        irq_en = 1'b0;
        drive(1'b1, 1'b0, 16'h00F0, 1'b1, 16'h0000, 1'b0);
        check("R9", "ctl_rdy dropped", ctl_rdy, 1'b0);
        check("R9", "dat_rdy dropped", dat_rdy, 1'b0);
        check("R10", "irq set", irq_sticky, 1'b1);
        check("R11", "irq_out gated off", irq_out, 1'b0);
        irq_en = 1'b1;
        #1;
        check("R11", "irq_out follows enable", irq_out, 1'b1);
        drive(1'b1, 1'b0, 16'h1234, 1'b0, 16'h5678, 1'b0);
        check("R9", "ready stays low", dat_rdy, 1'b0);
        check("R10", "irq holds", irq_sticky, 1'b1);

        // R9: software set restores both lines
        @(negedge clk); rdy_set = 1'b1;
        @(posedge clk); #1;
        check("R9", "ctl_rdy restored", ctl_rdy, 1'b1);
        check("R9", "dat_rdy restored", dat_rdy, 1'b1);
        check("R10", "irq survives rdy_set", irq_sticky, 1'b1);
        @(negedge clk); rdy_set = 1'b0; irq_clr = 1'b1;
        @(posedge clk); #1;
        check("R10", "irq cleared by w1c", irq_sticky, 1'b0);
        check("R11", "irq_out low", irq_out, 1'b0);

        // R9 R10: a mismatch wins over set and clear in the same cycle
        @(negedge clk);
        rdy_set = 1'b1; irq_clr = 1'b1;
        drive(1'b1, 1'b1, 16'h0000, 1'b0, 16'hFFFF, 1'b1);
        check("R9", "error beats rdy_set", ctl_rdy, 1'b0);
        check("R10", "error beats irq_clr", irq_sticky, 1'b1);
        check("R6", "final-word error", frm_stat_err, 1'b1);
        @(negedge clk);
        rdy_set = 1'b0; irq_clr = 1'b0; word_vld = 1'b0; frame_end = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule